// File: doc/BRIEF.md
# Per-Instruction Stride Prefetch Predictor

This block watches the stream of load and store instructions and learns, for each instruction separately, whether it steps through memory by a constant amount. Every memory access presents its program counter and effective address on a valid strobe. A small direct-mapped table is selected by the program counter. Each slot keeps an instruction tag, the last address that instruction touched, the learned stride and a confidence state. When that state says the stride can be trusted, the block proposes a prefetch of the current address plus the stride.

The confidence state has four values: INIT, TRANS (transient), STEADY and NOPRED (no prediction). Define the observed stride as the current address minus the stored previous address, computed modulo 2^32. A "match" means the observed stride equals the stored stride. The transitions are as follows:
- INIT, match: go to STEADY.
- INIT, mismatch: go to TRANS and store the observed stride.
- TRANS, match: go to STEADY.
- TRANS, mismatch: go to NOPRED and store the observed stride.
- STEADY, match: stay in STEADY.
- STEADY, mismatch: go to INIT and keep the stored stride.
- NOPRED, match: go to TRANS.
- NOPRED, mismatch: stay in NOPRED and store the observed stride.

On every access the stored previous address becomes the current address. A tag miss, or an empty slot, installs a new entry in INIT with a stride of zero. The prefetch result is registered and appears one clock after the access.

Top module: `srpt_top`

## Requirements
- R1: After reset every slot is empty and `pf_valid` is 0. The first access by any instruction after reset produces no prefetch.
- R2: An access whose slot is empty, or holds a different tag, produces no prefetch in the next cycle. It installs the entry in INIT with stride 0 and the previous address set to the access address. The slot index is `req_pc[5:2]` and the tag is `req_pc[31:6]`.
- R3: An access to an INIT entry whose observed stride matches the stored stride moves the entry to STEADY.
- R4: An access to an INIT entry with a mismatching stride stores the observed stride and moves the entry to TRANS. A prefetch of the address plus the new stride follows.
- R5: A matching access to a TRANS or STEADY entry leaves the entry in STEADY. A prefetch of the address plus the stride follows.
- R6: A mismatching access to a TRANS entry stores the observed stride, moves the entry to NOPRED and issues no prefetch.
- R7: A mismatching access to a STEADY entry moves the entry to INIT, keeps the old stride and issues no prefetch.
- R8: In NOPRED, a mismatch stores the observed stride and issues no prefetch. A match moves the entry to TRANS and issues a prefetch.
- R9: A prefetch is issued only when the entry's resulting state is TRANS or STEADY and its resulting stride is nonzero.
- R10: `pf_valid` and `pf_addr` are registered. They reflect the access of the previous cycle, and `pf_valid` is 0 in the cycle after a cycle with no access.
- R11: Strides are signed and all address arithmetic wraps modulo 2^32.
- R12: Instructions that map to different slots learn independently. An instruction with the same slot index but a different tag evicts the resident entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A memory instruction is presented this cycle |
| req_pc | input | 32 | Program counter of the memory instruction |
| req_addr | input | 32 | Effective address of the access |
| pf_valid | output | 1 | Prefetch proposal is valid |
| pf_addr | output | 32 | Proposed prefetch address |

## Verification
The assertions check, on every cycle, the rules that suppress prefetching: no access, a tag miss, a mismatch in TRANS or STEADY, and a zero stride. They also check that a confident STEADY entry always produces the address-plus-stride proposal. The scenario tests are needed for the multi-step behaviour: how many accesses a stream needs before it is trusted, the way back out of NOPRED, the stride kept across the fall from STEADY to INIT, wrap-around and negative strides, and eviction between aliasing instructions.

// File: rtl/srpt_pkg.sv
package srpt_pkg;

    typedef enum logic [1:0] {
        ST_INIT   = 2'd0,
        ST_TRANS  = 2'd1,
        ST_STEADY = 2'd2,
        ST_NOPRED = 2'd3
    } rpt_state_e;

endpackage

// File: rtl/srpt_index.sv
module srpt_index #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = PC_W - IDX_W - PC_LSB
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);

    assign idx = pc[PC_LSB +: IDX_W];
    assign tag = pc[PC_W-1 -: TAG_W];

    generate
        if (PC_LSB > 0) begin : g_lsb
            // low bits select bytes within an instruction word
            logic unused_lsb;
            assign unused_lsb = ^pc[PC_LSB-1:0];
        end
    endgenerate

endmodule

// File: rtl/srpt_table.sv
module srpt_table
    import srpt_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 26,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_prev,
    output logic [ADDR_W-1:0] rd_stride,
    output rpt_state_e        rd_state,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_prev,
    input  logic [ADDR_W-1:0] wr_stride,
    input  rpt_state_e        wr_state
);

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q    [ENTRIES];
    logic [ADDR_W-1:0]  prev_q   [ENTRIES];
    logic [ADDR_W-1:0]  stride_q [ENTRIES];
    rpt_state_e         state_q  [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                state_q[e]  <= ST_INIT;
                stride_q[e] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx]    <= 1'b1;
            state_q[wr_idx]  <= wr_state;
            stride_q[wr_idx] <= wr_stride;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            prev_q[wr_idx] <= wr_prev;
        end
    end

    always_comb begin
        rd_valid  = vld_q[rd_idx];
        rd_tag    = tag_q[rd_idx];
        rd_prev   = prev_q[rd_idx];
        rd_stride = stride_q[rd_idx];
        rd_state  = state_q[rd_idx];
    end

endmodule

// File: rtl/srpt_fsm.sv
module srpt_fsm
    import srpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              hit,
    input  rpt_state_e        cur_state,
    input  logic [ADDR_W-1:0] cur_stride,
    input  logic [ADDR_W-1:0] cur_prev,
    input  logic [ADDR_W-1:0] addr,
    output rpt_state_e        nxt_state,
    output logic [ADDR_W-1:0] nxt_stride,
    output logic              stride_eq,
    output logic              fire,
    output logic [ADDR_W-1:0] target
);

    logic [ADDR_W-1:0] obs_stride;

    assign obs_stride = addr - cur_prev;
    assign stride_eq  = (obs_stride == cur_stride);

    // next-state process
    always_comb begin
        nxt_state  = ST_INIT;
        nxt_stride = '0;
        if (hit) begin
            unique case (cur_state)
                ST_INIT: begin
                    nxt_state  = stride_eq ? ST_STEADY : ST_TRANS;
                    nxt_stride = stride_eq ? cur_stride : obs_stride;
                end
                ST_TRANS: begin
                    nxt_state  = stride_eq ? ST_STEADY : ST_NOPRED;
                    nxt_stride = stride_eq ? cur_stride : obs_stride;
                end
                ST_STEADY: begin
                    nxt_state  = stride_eq ? ST_STEADY : ST_INIT;
                    nxt_stride = cur_stride;
                end
                ST_NOPRED: begin
                    nxt_state  = stride_eq ? ST_TRANS : ST_NOPRED;
                    nxt_stride = stride_eq ? cur_stride : obs_stride;
                end
                default: begin
                    nxt_state  = ST_INIT;
                    nxt_stride = '0;
                end
            endcase
        end
    end

    // output process
    always_comb begin
        fire   = hit
              && (nxt_state == ST_STEADY || nxt_state == ST_TRANS)
              && (nxt_stride != '0);
        target = addr + nxt_stride;
    end

endmodule

// File: rtl/srpt_top.sv
module srpt_top
    import srpt_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int PC_LSB  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - PC_LSB;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              ent_valid;
    logic [TAG_W-1:0]  ent_tag;
    logic [ADDR_W-1:0] ent_prev;
    logic [ADDR_W-1:0] cur_stride;
    rpt_state_e        cur_state;
    logic              lk_hit;
    rpt_state_e        nxt_state;
    logic [ADDR_W-1:0] nxt_stride;
    logic              stride_eq;
    logic              fire;
    logic [ADDR_W-1:0] target;

    srpt_index #(
        .PC_W   (PC_W),
        .PC_LSB (PC_LSB),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) u_index (
        .pc  (req_pc),
        .idx (lk_idx),
        .tag (lk_tag)
    );

    srpt_table #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W),
        .ADDR_W  (ADDR_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (lk_idx),
        .rd_valid  (ent_valid),
        .rd_tag    (ent_tag),
        .rd_prev   (ent_prev),
        .rd_stride (cur_stride),
        .rd_state  (cur_state),
        .wr_en     (req_valid),
        .wr_idx    (lk_idx),
        .wr_tag    (lk_tag),
        .wr_prev   (req_addr),
        .wr_stride (nxt_stride),
        .wr_state  (nxt_state)
    );

    assign lk_hit = ent_valid && (ent_tag == lk_tag);

    srpt_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .hit        (lk_hit),
        .cur_state  (cur_state),
        .cur_stride (cur_stride),
        .cur_prev   (ent_prev),
        .addr       (req_addr),
        .nxt_state  (nxt_state),
        .nxt_stride (nxt_stride),
        .stride_eq  (stride_eq),
        .fire       (fire),
        .target     (target)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= req_valid && fire;
            pf_addr  <= target;
        end
    end

endmodule

// File: rtl/srpt_chk.sv
module srpt_chk
    import srpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              pf_valid,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              lk_hit,
    input rpt_state_e        cur_state,
    input logic [ADDR_W-1:0] cur_stride,
    input logic              stride_eq
);

    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n) !$isunknown(pf_valid)); // R1
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_valid && !lk_hit |=> !pf_valid); // R2
    AST_STEADY_PF: assert property (@(posedge clk) disable iff (!rst_n) req_valid && lk_hit && cur_state == ST_STEADY && stride_eq && cur_stride != '0 |=> pf_valid && pf_addr == $past(req_addr) + $past(cur_stride)); // R5
    AST_TRANS_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_valid && lk_hit && cur_state == ST_TRANS && !stride_eq |=> !pf_valid); // R6
    AST_STEADY_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_valid && lk_hit && cur_state == ST_STEADY && !stride_eq |=> !pf_valid); // R7
    AST_NONZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> !pf_valid || pf_addr != $past(req_addr)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !pf_valid); // R10

endmodule

bind srpt_top srpt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .pf_valid   (pf_valid),
    .pf_addr    (pf_addr),
    .lk_hit     (lk_hit),
    .cur_state  (cur_state),
    .cur_stride (cur_stride),
    .stride_eq  (stride_eq)
);

// File: tb/sim_srpt_top.sv
module sim_srpt_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_pc;
    logic [31:0] req_addr;
    logic        pf_valid;
    logic [31:0] pf_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    srpt_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_pc    (req_pc),
        .req_addr  (req_addr),
        .pf_valid  (pf_valid),
        .pf_addr   (pf_addr)
    );

    // PCs: index = pc[5:2], tag = pc[31:6]
    localparam logic [31:0] PC_A = 32'h0040_0000; // slot 0
    localparam logic [31:0] PC_B = 32'h0040_0004; // slot 1
    localparam logic [31:0] PC_C = 32'h0040_0008; // slot 2
    localparam logic [31:0] PC_D = 32'h0040_000C; // slot 3
    localparam logic [31:0] PC_E = 32'h0040_0010; // slot 4
    localparam logic [31:0] PC_F = 32'h0040_0014; // slot 5
    localparam logic [31:0] PC_G = 32'h0080_0014; // slot 5, other tag
    localparam logic [31:0] PC_H = 32'h0040_0018; // slot 6

    task automatic check(input string rq, input bit ev, input logic [31:0] ea);
        n_chk++;
        if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
            n_fail++;
            $display("FAIL %s: pf_valid=%0b pf_addr=%08h, expected pf_valid=%0b pf_addr=%08h",
                     rq, pf_valid, pf_addr, ev, ea);
        end
    endtask

    // one access; the registered result is sampled at the following falling edge
    task automatic acc(input logic [31:0] pc, input logic [31:0] addr,
                       input bit ev, input logic [31:0] ea, input string rq);
        @(negedge clk);
        req_valid = 1'b1;
        req_pc    = pc;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        check(rq, ev, ea);
    endtask

    task automatic t_reset();
        check("R1 reset", 1'b0, 32'h0);
        acc(PC_A, 32'h0000_1000, 1'b0, 32'h0, "R1 first access");
    endtask

    task automatic t_stream();
        acc(PC_A, 32'h0000_1004, 1'b1, 32'h0000_1008, "R4 init mismatch");
        acc(PC_A, 32'h0000_1008, 1'b1, 32'h0000_100C, "R5 trans match");
        acc(PC_A, 32'h0000_100C, 1'b1, 32'h0000_1010, "R5 steady match");
        @(negedge clk);
        check("R10 idle", 1'b0, 32'h0);
    endtask

    task automatic t_steady_break();
        acc(PC_A, 32'h0000_2000, 1'b0, 32'h0, "R7 steady mismatch");
        acc(PC_A, 32'h0000_2004, 1'b1, 32'h0000_2008, "R7 kept stride R3");
    endtask

    task automatic t_nopred();
        acc(PC_B, 32'h0000_0100, 1'b0, 32'h0, "R2 alloc");
        acc(PC_B, 32'h0000_0110, 1'b1, 32'h0000_0120, "R4 trans");
        acc(PC_B, 32'h0000_0118, 1'b0, 32'h0, "R6 trans mismatch");
        acc(PC_B, 32'h0000_011C, 1'b0, 32'h0, "R8 nopred mismatch");
        acc(PC_B, 32'h0000_0120, 1'b1, 32'h0000_0124, "R8 nopred match");
    endtask

    task automatic t_zero();
        acc(PC_C, 32'h0000_0500, 1'b0, 32'h0, "R2 alloc");
        acc(PC_C, 32'h0000_0500, 1'b0, 32'h0, "R3 R9 zero stride steady");
        acc(PC_C, 32'h0000_0500, 1'b0, 32'h0, "R9 zero stride");
        acc(PC_C, 32'h0000_0508, 1'b0, 32'h0, "R7 steady mismatch");
        acc(PC_C, 32'h0000_0510, 1'b1, 32'h0000_0518, "R4 init mismatch");
    endtask

    task automatic t_neg();
        acc(PC_D, 32'h0000_0080, 1'b0, 32'h0, "R2 alloc");
        acc(PC_D, 32'h0000_0078, 1'b1, 32'h0000_0070, "R11 negative");
        acc(PC_D, 32'h0000_0070, 1'b1, 32'h0000_0068, "R11 negative steady");
        acc(PC_E, 32'h0000_0004, 1'b0, 32'h0, "R2 alloc");
        acc(PC_E, 32'hFFFF_FFFC, 1'b1, 32'hFFFF_FFF4, "R11 wrap down");
        acc(PC_E, 32'hFFFF_FFF4, 1'b1, 32'hFFFF_FFEC, "R11 wrap steady");
        acc(PC_H, 32'hFFFF_FFF8, 1'b0, 32'h0, "R2 alloc");
        acc(PC_H, 32'h0000_0000, 1'b1, 32'h0000_0008, "R11 wrap up");
    endtask

    task automatic t_alias();
        acc(PC_F, 32'h0000_3000, 1'b0, 32'h0, "R2 alloc");
        acc(PC_F, 32'h0000_3020, 1'b1, 32'h0000_3040, "R12 build");
        acc(PC_G, 32'h0000_7000, 1'b0, 32'h0, "R12 R2 alias miss");
        acc(PC_F, 32'h0000_3040, 1'b0, 32'h0, "R12 evicted");
        acc(PC_F, 32'h0000_3060, 1'b1, 32'h0000_3080, "R12 relearn");
        acc(PC_D, 32'h0000_0068, 1'b1, 32'h0000_0060, "R12 other slot kept");
        acc(PC_F, 32'h0000_3080, 1'b1, 32'h0000_30A0, "R12 interleaved");
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_pc    = '0;
        req_addr  = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stream();
        t_steady_break();
        t_nopred();
        t_zero();
        t_neg();
        t_alias();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule